// File: doc/BRIEF.md
# Cache Invalidate Special-Cycle Sequencer

This block carries out a whole-cache invalidate for a processor with split instruction and data caches. A start request taken while the sequencer is idle launches a sweep. The sweep walks every set index once, one index per clock, and asserts the valid-bit clear strobe of both tag arrays together. Modified data lines are simply dropped. The sweep has no path that could write them back, and the bus stays idle for its whole length.

Once the last index has been cleared, the sequencer runs one special bus cycle. The byte-enable lines carry a fixed code that marks the cycle as a cache-invalidate notice. The cycle stays open until the system answers with ready. A one-clock done pulse then tells the refill logic that it may start its burst reads.

Top module: `cache_inv_seq`

## Requirements
- R1: A synchronous active-high reset forces: busy_o=0, done_o=0, both clear enables 0, ads_n_o=1, be_n_o=8'hFF, mio_o=0, dc_o=0, wr_o=0.
- R2: When start_i is sampled high while idle, the next NUM_SETS clocks raise both clear enables together. Both index outputs carry the same value, running 0, 1, ... NUM_SETS-1, one step per clock.
- R3: For the whole sweep, ads_n_o stays high and be_n_o stays 8'hFF. No bus cycle is started, whatever the state of the data lines.
- R4: In the clock right after the last index, ads_n_o is low for exactly one clock. In that clock be_n_o=8'hFD, mio_o=0, dc_o=0 and wr_o=1.
- R5: be_n_o, mio_o, dc_o and wr_o keep their special-cycle values until rdy_n_i is sampled low in a clock after the strobe clock. rdy_n_i low during the strobe clock is ignored.
- R6: In the clock after ready is accepted, the bus returns to the R1 idle values. done_o is then high for exactly one clock.
- R7: start_i is ignored while busy_o is high. It neither restarts the sweep nor resets the index, and each accepted start gives exactly one done pulse.
- R8: busy_o is high from the clock after a start is accepted until the clock in which done_o rises, and low at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Invalidate request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse; refill may begin |
| ic_clr_en_o | output | 1 | Instruction tag array valid-clear strobe |
| ic_clr_idx_o | output | IDX_W | Instruction tag array set index |
| dc_clr_en_o | output | 1 | Data tag array valid-clear strobe |
| dc_clr_idx_o | output | IDX_W | Data tag array set index |
| ads_n_o | output | 1 | Address strobe, active low |
| be_n_o | output | 8 | Byte enables, active low |
| mio_o | output | 1 | Memory/IO cycle type |
| dc_o | output | 1 | Data/control cycle type |
| wr_o | output | 1 | Write/read cycle type |
| rdy_n_i | input | 1 | Ready acknowledge, active low |

## Verification
A wrong index counter shows up at once on the clear index ports. It also moves the strobe clock earlier or later, so the bus cycle starts off its expected clock. A control state stuck in the sweep or the bus phase shows as busy_o failing to drop, or done_o missing or repeating, within a clock of the expected completion. A bus register that loses its hold shows as a byte-enable or cycle-type change in the first wait clock. The reference model is compared on every clock, so each of these faults is reported in the clock where it first appears.

// File: rtl/inv_seq_pkg.sv
package inv_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SWEEP, ST_BUS} seq_state_e;
  localparam logic [7:0] BE_INVAL_CODE = 8'hFD;
  localparam logic [7:0] BE_NONE       = 8'hFF;
endpackage

// File: rtl/inv_sweep_ctr.sv
module inv_sweep_ctr #(
  parameter int NUM_SETS = 128,
  parameter int IDX_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SETS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) idx_q <= '0;
    else if (step_i)    idx_q <= idx_q + IDX_W'(1);
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  // R2: one index per clock while stepping
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !last_o && !clear_i) |=> (idx_o == $past(idx_o) + IDX_W'(1)));
endmodule

// File: rtl/inv_bus_cycle.sv
module inv_bus_cycle
  import inv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic       rdy_n_i,
  output logic       ads_n_o,
  output logic [7:0] be_n_o,
  output logic       mio_o,
  output logic       dc_o,
  output logic       wr_o,
  output logic       accept_o,
  output logic       ack_o
);
  logic       active_q;
  logic       ads_n_q;
  logic [7:0] be_q;
  logic       wr_q;
  logic       ack_q;

  // ready counts only after the strobe clock has passed
  assign accept_o = active_q && ads_n_q && !rdy_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ads_n_q  <= 1'b1;
      be_q     <= BE_NONE;
      wr_q     <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q   <= accept_o;
      ads_n_q <= 1'b1;
      if (go_i) begin
        active_q <= 1'b1;
        ads_n_q  <= 1'b0;
        be_q     <= BE_INVAL_CODE;
        wr_q     <= 1'b1;
      end else if (accept_o) begin
        active_q <= 1'b0;
        be_q     <= BE_NONE;
        wr_q     <= 1'b0;
      end
    end
  end

  assign ads_n_o = ads_n_q;
  assign be_n_o  = be_q;
  assign wr_o    = wr_q;
  assign mio_o   = 1'b0;   // special cycle type: memory/IO low
  assign dc_o    = 1'b0;   // special cycle type: data/control low
  assign ack_o   = ack_q;

  // R4: strobe lasts a single clock
  assert_ads_one_clk_R4: assert property (@(posedge clk) disable iff (rst)
    !ads_n_o |=> ads_n_o);
  // R4: strobe clock carries the invalidate code
  assert_ads_code_R4: assert property (@(posedge clk) disable iff (rst)
    !ads_n_o |-> (be_n_o == BE_INVAL_CODE && wr_o));
  // R5: cycle attributes held until ready is accepted
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (active_q && !accept_o && !go_i) |=> ($stable(be_n_o) && $stable(wr_o)));
  // R6: completion is a single-clock pulse
  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);
endmodule

// File: rtl/cache_inv_seq.sv
module cache_inv_seq
  import inv_seq_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int IDX_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ic_clr_en_o,
  output logic [IDX_W-1:0] ic_clr_idx_o,
  output logic             dc_clr_en_o,
  output logic [IDX_W-1:0] dc_clr_idx_o,
  output logic             ads_n_o,
  output logic [7:0]       be_n_o,
  output logic             mio_o,
  output logic             dc_o,
  output logic             wr_o,
  input  logic             rdy_n_i
);
  seq_state_e       state_q;
  logic             start_acc;
  logic             sweeping;
  logic             last_idx;
  logic             bus_go;
  logic             bus_accept;
  logic             bus_ack;
  logic [IDX_W-1:0] idx;

  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign sweeping  = (state_q == ST_SWEEP);
  assign bus_go    = sweeping && last_idx;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:  if (start_acc)  state_q <= ST_SWEEP;
        ST_SWEEP: if (last_idx)   state_q <= ST_BUS;
        ST_BUS:   if (bus_accept) state_q <= ST_IDLE;
        default:                  state_q <= ST_IDLE;
      endcase
    end
  end

  inv_sweep_ctr #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_acc),
    .step_i  (sweeping),
    .idx_o   (idx),
    .last_o  (last_idx)
  );

  inv_bus_cycle u_bus (
    .clk      (clk),
    .rst      (rst),
    .go_i     (bus_go),
    .rdy_n_i  (rdy_n_i),
    .ads_n_o  (ads_n_o),
    .be_n_o   (be_n_o),
    .mio_o    (mio_o),
    .dc_o     (dc_o),
    .wr_o     (wr_o),
    .accept_o (bus_accept),
    .ack_o    (bus_ack)
  );

  assign ic_clr_en_o  = sweeping;
  assign dc_clr_en_o  = sweeping;
  assign ic_clr_idx_o = idx;
  assign dc_clr_idx_o = idx;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = bus_ack;

  // R3: bus silent for the whole sweep
  assert_silent_sweep_R3: assert property (@(posedge clk) disable iff (rst)
    sweeping |-> (ads_n_o && be_n_o == BE_NONE));
  // R7: a start while busy does not rewind the index
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (sweeping && start_i && !last_idx) |=> (idx != '0));
  // R8: done rises as busy falls
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_cache_inv_seq.sv
module tb_cache_inv_seq;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          rdy_n_i = 1'b1;
  logic          busy_o, done_o, ic_en, dc_en, ads_n_o, mio_o, dc_o, wr_o;
  logic [IW-1:0] ic_idx, dc_idx;
  logic [7:0]    be_n_o;

  int total = 0;
  int bad   = 0;
  int done_seen = 0;

  // model: 0 idle, 1 sweep, 2 strobe, 3 wait
  int m_state = 0;
  int m_idx   = 0;
  bit m_done  = 1'b0;

  always #5 clk = ~clk;

  cache_inv_seq #(.NUM_SETS(N)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .ic_clr_en_o(ic_en), .ic_clr_idx_o(ic_idx), .dc_clr_en_o(dc_en),
    .dc_clr_idx_o(dc_idx), .ads_n_o(ads_n_o), .be_n_o(be_n_o), .mio_o(mio_o),
    .dc_o(dc_o), .wr_o(wr_o), .rdy_n_i(rdy_n_i)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_idx = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_state)
        0: if (start_i) begin m_state = 1; m_idx = 0; end
        1: if (m_idx == N-1) m_state = 2; else m_idx++;
        2: m_state = 3;
        default: if (!rdy_n_i) begin m_state = 0; m_done = 1'b1; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (done_o) done_seen++;
    check("R8", "busy", busy_o, m_state != 0);
    check("R6", "done", done_o, m_done);
    check("R2", "ic_en", ic_en, m_state == 1);
    check("R2", "dc_en", dc_en, m_state == 1);
    if (m_state == 1) begin
      check("R2", "ic_idx", ic_idx, m_idx);
      check("R2", "dc_idx", dc_idx, m_idx);
    end
    check((m_state == 1) ? "R3" : "R4", "ads_n", ads_n_o, m_state != 2);
    check((m_state == 1) ? "R3" : "R5", "be_n", be_n_o,
          (m_state >= 2) ? 8'hFD : 8'hFF);
    check("R5", "wr", wr_o, m_state >= 2);
    check("R4", "mio", mio_o, 0);
    check("R4", "dc", dc_o, 0);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset values
    check("R1", "reset busy", busy_o, 0);
    check("R1", "reset be_n", be_n_o, 8'hFF);
    check("R1", "reset ads_n", ads_n_o, 1);
    // plain run, three wait clocks
    start_i = 1'b1; idle(1); start_i = 1'b0;
    idle(N + 1 + 3);
    rdy_n_i = 1'b0; idle(1); rdy_n_i = 1'b1;
    idle(4);
    check("R6", "done count run1", done_seen, 1);
    // R7: start held through part of the sweep; R5: ready low in strobe clock
    start_i = 1'b1; idle(5); start_i = 1'b0;
    idle(N - 4);
    rdy_n_i = 1'b0; idle(2); rdy_n_i = 1'b1;
    idle(6);
    check("R7", "done count run2", done_seen, 2);
    // start during the wait phase is ignored (R7)
    start_i = 1'b1; idle(1); start_i = 1'b0;
    idle(N + 2);
    start_i = 1'b1; idle(1); start_i = 1'b0;
    idle(2);
    rdy_n_i = 1'b0; idle(1); rdy_n_i = 1'b1;
    idle(4);
    check("R7", "done count run3", done_seen, 3);
    check("R8", "busy after run3", busy_o, 0);
    // reset in the middle of a sweep (R1)
    start_i = 1'b1; idle(1); start_i = 1'b0;
    idle(3);
    rst = 1'b1; idle(1); rst = 1'b0;
    check("R1", "mid-sweep reset busy", busy_o, 0);
    check("R1", "mid-sweep reset clr", ic_en, 0);
    // restart after reset, ready already low when strobe begins
    start_i = 1'b1; idle(1); start_i = 1'b0;
    rdy_n_i = 1'b0;
    idle(N + 6);
    rdy_n_i = 1'b1;
    idle(3);
    check("R6", "done count run4", done_seen, 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R8 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule